// File: doc/BRIEF.md
# Power-of-Two Sample Averager

This block sums a run of raw 12-bit conversion samples and emits one 16-bit averaged word per run. The run length is a power of two, chosen by a 4-bit log2 code. A 3-bit shift code divides the sum by a power of two. The shifted value is clipped to 16 bits.

A run begins on a start pulse, or on its own in free-running mode. The block takes samples over a valid/ready handshake. Ready is high only while a run is in progress; samples offered at other times are not taken. The result side has no back-pressure. A result that arrives while the previous one is still unacknowledged sets a sticky overrun flag. An acknowledge input clears both the unread state and the overrun flag.

When the run is a single sample, the output is the raw 12-bit value. That value is right-justified, or moved to the upper bits when left-adjust is set.

Top module: `pow2_averager`

## Requirements
- R1: With log2 code n from 0 to 10, exactly 2^n samples are accepted in a run, and the result appears only after the last of them. Codes 11 to 15 behave as code 10, which is 1024 samples.
- R2: When n is 1 or more, the result equals the sum of the run's samples shifted right by the 3-bit shift code. If that value exceeds 0xFFFF, the result is 0xFFFF.
- R3: When n is 0, the result is the single sample. With left-adjust clear it is {4'h0, sample}. With left-adjust set it is {sample, 4'h0}. The shift code has no effect in this case.
- R4: When n is 1 or more, left-adjust has no effect on the result.
- R5: `res_rdy_o` is high for one cycle, in the cycle after the last sample of a run is accepted. `result_o` takes its new value in that same cycle and holds it until the next result.
- R6: A start pulse while idle raises `busy_o` and `smp_ready_o` from the next cycle. A start pulse during a run is ignored and does not restart the sample count.
- R7: A sample is accepted only in a cycle where `smp_valid_i` and `smp_ready_o` are both high. Samples offered while idle are discarded.
- R8: If `free_run_i` is high when the last sample of a run is accepted, `busy_o` stays high and a new run starts at once. If `free_run_i` is low at that point, `busy_o` falls in the following cycle.
- R9: `overrun_o` is set when a result completes while the previous result is still unacknowledged. `rd_ack_i` clears both the overrun flag and the unread state. If an acknowledge arrives in the same cycle as a completion, the old result counts as read and no overrun is raised.
- R10: After reset, `result_o` is 0 and `res_rdy_o`, `overrun_o` and `busy_o` are all low.
- R11: The log2 code, shift code and left-adjust are sampled when a run begins, either from a start pulse or from a free-running restart. Changes to them during a run do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (used only while idle) |
| free_run_i | input | 1 | Restart automatically after each result |
| left_adj_i | input | 1 | Put a single-sample result in the upper bits |
| count_code_i | input | 4 | Log2 of the samples per run |
| adj_code_i | input | 3 | Right-shift applied to the sum |
| smp_valid_i | input | 1 | Sample valid |
| smp_ready_o | output | 1 | Sample ready (high during a run) |
| smp_data_i | input | 12 | Raw sample |
| rd_ack_i | input | 1 | Acknowledge the current result |
| result_o | output | 16 | Averaged result |
| res_rdy_o | output | 1 | One-cycle result pulse |
| overrun_o | output | 1 | Sticky overrun flag |
| busy_o | output | 1 | Run in progress |

## Verification
The assertions assume that every input is a known value after reset is released. They also assume that the configuration inputs matter only in the cycle where a run is entered, since the block latches them there. The stimulus changes inputs only on the falling clock edge and always to defined values. It changes the configuration in the middle of a run on purpose, to confirm that only the latched copy is used. Acknowledge pulses are placed both apart from completions and in the same cycle as one, so that both branches of the overrun rule are reached.

// File: rtl/avg_pkg.sv
`timescale 1ns/1ps
package avg_pkg;
  localparam int CODE_W = 4;
  localparam int SHIFT_W = 3;

  typedef struct packed {
    logic [CODE_W-1:0]  log2n;
    logic [SHIFT_W-1:0] shift;
    logic               left;
  } avg_cfg_t;

  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] code,
                                                   input int max_log);
    return (code > CODE_W'(max_log)) ? CODE_W'(max_log) : code;
  endfunction
endpackage

// File: rtl/avg_accum.sv
`timescale 1ns/1ps
module avg_accum
  import avg_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int MAX_LOG = 10,
  localparam int ACC_W  = SMP_W + MAX_LOG,
  localparam int CNT_W  = (MAX_LOG < 1) ? 1 : MAX_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             free_run_i,
  input  avg_cfg_t         cfg_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [ACC_W-1:0] sum_o,
  output avg_cfg_t         cfg_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;
  avg_cfg_t         cfg_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] target;
  logic             take;

  assign span   = (CNT_W+1)'(1) << cfg_q.log2n;
  assign target = CNT_W'(span - (CNT_W+1)'(1));
  assign take   = busy_q & smp_valid_i;
  assign last_o = take & (cnt_q == target);
  assign sum_o  = acc_q + ACC_W'(smp_data_i);
  assign busy_o = busy_q;
  assign cfg_o  = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      cfg_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        acc_q  <= '0;
        cfg_q  <= cfg_i;
      end
    end else if (last_o) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      busy_q <= free_run_i;
      if (free_run_i) cfg_q <= cfg_i;
    end else if (take) begin
      cnt_q <= cnt_q + CNT_W'(1);
      acc_q <= sum_o;
    end
  end

  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= target));
  a_r7_idle_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !smp_valid_i) |=> ($stable(cnt_q) && $stable(acc_q)));
  a_r6_fresh_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q == '0 && acc_q == '0));
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> $stable(cfg_q));
  a_r8_free_run_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && free_run_i) |=> busy_q);
endmodule

// File: rtl/avg_format.sv
`timescale 1ns/1ps
module avg_format
  import avg_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int ACC_W = 22,
  parameter int RES_W = 16,
  localparam int PAD_W = RES_W - SMP_W
) (
  input  logic [ACC_W-1:0] sum_i,
  input  avg_cfg_t         cfg_i,
  output logic [RES_W-1:0] res_o
);
  logic [ACC_W-1:0] shifted;
  logic [SMP_W-1:0] single;

  assign shifted = sum_i >> cfg_i.shift;
  assign single  = sum_i[SMP_W-1:0];

  always_comb begin
    if (cfg_i.log2n == '0) begin
      res_o = cfg_i.left ? {single, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, single};
    end else if (shifted > ACC_W'({RES_W{1'b1}})) begin
      res_o = '1;
    end else begin
      res_o = shifted[RES_W-1:0];
    end
  end
endmodule

// File: rtl/avg_status.sv
`timescale 1ns/1ps
module avg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic ack_i,
  output logic overrun_o
);
  logic unread_q;
  logic ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unread_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (done_i)     unread_q <= 1'b1;
      else if (ack_i) unread_q <= 1'b0;
      if (done_i && unread_q && !ack_i) ovr_q <= 1'b1;
      else if (ack_i)                   ovr_q <= 1'b0;
    end
  end

  assign overrun_o = ovr_q;

  a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(done_i));
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !done_i) |=> (!ovr_q && !unread_q));
  a_r9_ack_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && done_i) |=> (unread_q && !ovr_q));
endmodule

// File: rtl/pow2_averager.sv
`timescale 1ns/1ps
module pow2_averager
  import avg_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int MAX_LOG = 10,
  parameter int RES_W   = 16,
  localparam int ACC_W  = SMP_W + MAX_LOG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               free_run_i,
  input  logic               left_adj_i,
  input  logic [CODE_W-1:0]  count_code_i,
  input  logic [SHIFT_W-1:0] adj_code_i,
  input  logic               smp_valid_i,
  output logic               smp_ready_o,
  input  logic [SMP_W-1:0]   smp_data_i,
  input  logic               rd_ack_i,
  output logic [RES_W-1:0]   result_o,
  output logic               res_rdy_o,
  output logic               overrun_o,
  output logic               busy_o
);
  avg_cfg_t         cfg_in;
  avg_cfg_t         cfg_run;
  logic             last_w;
  logic             busy_w;
  logic [ACC_W-1:0] sum_w;
  logic [RES_W-1:0] fmt_w;
  logic [RES_W-1:0] result_q;
  logic             rdy_q;

  assign cfg_in.log2n = clamp_code(count_code_i, MAX_LOG);
  assign cfg_in.shift = adj_code_i;
  assign cfg_in.left  = left_adj_i;

  avg_accum #(.SMP_W(SMP_W), .MAX_LOG(MAX_LOG)) u_accum (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .free_run_i(free_run_i),
    .cfg_i(cfg_in), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .busy_o(busy_w), .last_o(last_w), .sum_o(sum_w), .cfg_o(cfg_run)
  );

  avg_format #(.SMP_W(SMP_W), .ACC_W(ACC_W), .RES_W(RES_W)) u_format (
    .sum_i(sum_w), .cfg_i(cfg_run), .res_o(fmt_w)
  );

  avg_status u_status (
    .clk(clk), .rst_n(rst_n), .done_i(last_w), .ack_i(rd_ack_i),
    .overrun_o(overrun_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      rdy_q    <= 1'b0;
    end else begin
      rdy_q <= last_w;
      if (last_w) result_q <= fmt_w;
    end
  end

  assign result_o    = result_q;
  assign res_rdy_o   = rdy_q;
  assign busy_o      = busy_w;
  assign smp_ready_o = busy_w;

  a_r5_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !last_w |=> ($stable(result_q) && !rdy_q));
  a_r3_right_justified: assert property (@(posedge clk) disable iff (!rst_n)
    (last_w && cfg_run.log2n == '0 && !cfg_run.left) |=> (result_q[RES_W-1:SMP_W] == '0));
  a_r3_left_justified: assert property (@(posedge clk) disable iff (!rst_n)
    (last_w && cfg_run.log2n == '0 && cfg_run.left) |=> (result_q[RES_W-SMP_W-1:0] == '0));
endmodule

// File: tb/pow2_averager_tb.sv
`timescale 1ns/1ps
module pow2_averager_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        free_run_i = 1'b0;
  logic        left_adj_i = 1'b0;
  logic [3:0]  count_code_i = 4'd0;
  logic [2:0]  adj_code_i = 3'd0;
  logic        smp_valid_i = 1'b0;
  logic        smp_ready_o;
  logic [11:0] smp_data_i = 12'd0;
  logic        rd_ack_i = 1'b0;
  logic [15:0] result_o;
  logic        res_rdy_o;
  logic        overrun_o;
  logic        busy_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pow2_averager u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .free_run_i(free_run_i),
    .left_adj_i(left_adj_i), .count_code_i(count_code_i), .adj_code_i(adj_code_i),
    .smp_valid_i(smp_valid_i), .smp_ready_o(smp_ready_o), .smp_data_i(smp_data_i),
    .rd_ack_i(rd_ack_i), .result_o(result_o), .res_rdy_o(res_rdy_o),
    .overrun_o(overrun_o), .busy_o(busy_o)
  );

  // columns: log2 code, shift, left-adjust, first sample, step
  localparam int unsigned TBL [0:8][0:4] = '{
    '{0,  3, 0, 12'hABC, 0},
    '{0,  0, 1, 12'h123, 0},
    '{2,  2, 0, 100,     7},
    '{4,  0, 1, 12'hFFF, 0},
    '{5,  0, 0, 12'hFFF, 0},
    '{10, 4, 0, 12'h800, 3},
    '{15, 7, 0, 12'hFFF, 0},
    '{3,  1, 1, 12'h010, 12'h111},
    '{1,  0, 0, 12'hFFF, 1}
  };

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic feed(input int d);
    smp_valid_i = 1'b1;
    smp_data_i  = 12'(d);
    @(negedge clk);
    smp_valid_i = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    step();
    start_i = 1'b0;
  endtask

  task automatic ack();
    rd_ack_i = 1'b1;
    step();
    rd_ack_i = 1'b0;
  endtask

  task automatic run_vec(input int code, input int adj, input int left,
                         input int base, input int stp);
    int eff;
    int n;
    longint sum;
    longint exp;
    int d0;
    eff = (code > 10) ? 10 : code;
    n = 1 << eff;
    sum = 0;
    d0 = base & 'hFFF;
    count_code_i = 4'(code);
    adj_code_i = 3'(adj);
    left_adj_i = left[0];
    free_run_i = 1'b0;
    pulse_start();
    check("R6 busy after start", busy_o, 1);
    for (int i = 0; i < n; i++) begin
      int d;
      d = (base + i * stp) & 'hFFF;
      sum += d;
      feed(d);
      if (i < n - 1 && res_rdy_o !== 1'b0) check("R1 early result", res_rdy_o, 0);
    end
    if (eff == 0) exp = left ? (d0 << 4) : d0;
    else begin
      exp = sum >> adj;
      if (exp > 65535) exp = 65535;
    end
    check("R1 result after 2^n samples", res_rdy_o, 1);
    if (eff == 0) check("R3 single sample", result_o, exp);
    else if (left != 0) check("R4 left-adjust ignored", result_o, exp);
    else check("R2 shifted sum", result_o, exp);
    check("R8 busy falls", busy_o, 0);
    step();
    check("R5 one-cycle pulse", res_rdy_o, 0);
    check("R5 result holds", result_o, exp);
    ack();
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step();
    check("R10 reset result", result_o, 0);
    check("R10 reset busy", busy_o, 0);
    rst_n = 1'b1;
    step();
    check("R10 result after release", result_o, 0);
    check("R10 rdy after release", res_rdy_o, 0);
    check("R10 overrun after release", overrun_o, 0);
    check("R10 busy after release", busy_o, 0);

    for (int v = 0; v < 9; v++)
      run_vec(int'(TBL[v][0]), int'(TBL[v][1]), int'(TBL[v][2]),
              int'(TBL[v][3]), int'(TBL[v][4]));

    // R7: samples offered while idle are discarded
    smp_valid_i = 1'b1;
    smp_data_i = 12'hFFF;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R7 not ready while idle", smp_ready_o, 0);
    end
    smp_valid_i = 1'b0;
    count_code_i = 4'd1; adj_code_i = 3'd0; left_adj_i = 1'b0;
    pulse_start();
    feed(1);
    feed(2);
    check("R7 idle samples dropped", result_o, 3);
    ack();

    // R6: start during a run is ignored
    count_code_i = 4'd2;
    pulse_start();
    feed(1);
    feed(2);
    start_i = 1'b1;
    feed(3);
    start_i = 1'b0;
    check("R6 no result yet", res_rdy_o, 0);
    feed(4);
    check("R6 restart ignored", res_rdy_o, 1);
    check("R6 sum of four", result_o, 10);
    ack();

    // R8/R11/R9: free run, config change mid-run, overrun
    free_run_i = 1'b1;
    count_code_i = 4'd1; adj_code_i = 3'd0; left_adj_i = 1'b0;
    pulse_start();
    count_code_i = 4'd0; left_adj_i = 1'b1;
    feed(10);
    check("R11 mid-run change ignored", res_rdy_o, 0);
    feed(20);
    check("R11 old config used", result_o, 30);
    check("R8 busy stays in free run", busy_o, 1);
    feed(5);
    check("R8 restart with new config", result_o, 16'h0050);
    check("R9 overrun on unread", overrun_o, 1);
    free_run_i = 1'b0;
    feed(6);
    check("R8 last free-run result", result_o, 16'h0060);
    check("R8 busy falls when free run off", busy_o, 0);
    ack();
    check("R9 ack clears overrun", overrun_o, 0);

    // R9: ack in the completion cycle
    count_code_i = 4'd0; left_adj_i = 1'b0;
    pulse_start();
    feed(7);
    pulse_start();
    rd_ack_i = 1'b1;
    feed(8);
    rd_ack_i = 1'b0;
    check("R9 same-cycle ack no overrun", overrun_o, 0);
    check("R3 latest single sample", result_o, 8);
    step();
    check("R9 still no overrun", overrun_o, 0);
    ack();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule